// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block turns an asynchronous serial line into received characters for a host that polls it through a small register window. It samples the line on a clock-enable tick that runs at one, sixteen or sixty-four times the bit rate. It finds a start bit and samples each later bit near the middle of its period. It checks an optional parity bit and the first stop bit, then places the character in a one-entry holding buffer.

The host picks the character width, parity and sampling factor by writing a mode byte. It turns reception on and clears error flags by writing a command byte. It polls a status byte and reads the character from the data address. The error flags are sticky: once set, each one stays set until the host writes the command byte with the error-clear bit set.

Host register map: address 0 returns the buffered character on a read. Address 1 returns status on a read and takes the command byte on a write. Address 2 takes the mode byte on a write. Every other read returns zero.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, the status and data reads both return 0x00, reception is off and the mode byte is 0x00.
- R2: Mode bits [3:2] set the character width: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits arrive least significant first. Buffer bits above the chosen width read as zero.
- R3: Mode bit 4 turns parity checking on. Mode bit 5 selects even parity when 1 and odd parity when 0. A parity mismatch sets status bit 3.
- R4: Mode bits [1:0] set the sampling factor: 00 and 01 give 1X, 10 gives 16X and 11 gives 64X. At 16X and 64X each bit is sampled at the middle of its period. At 1X each bit is sampled on the tick after the one that found the previous bit.
- R5: At 16X and 64X, the start bit is accepted only if the line is still low half a bit period after the falling edge was seen. A shorter low pulse produces no character.
- R6: Command bit 2 turns reception on. While it is 0, no character is captured and the status stays unchanged.
- R7: Status bit 1 goes high when a character is stored. A read of address 0 clears it.
- R8: If a character completes while status bit 1 is still high, status bit 4 (overrun) is set and the new character replaces the old one.
- R9: If the first stop bit samples low, status bit 5 (framing) is set. The character is still stored and still raises status bit 1.
- R10: A command write with bit 4 set clears status bits 3, 4 and 5. Nothing else clears them, including data reads and command writes with bit 4 clear. Status bits 0, 2, 6 and 7 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| os_tick | input | 1 | Oversampling clock enable, one pulse per sample period |
| rx_line | input | 1 | Serial input line, idles high |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_addr | input | 2 | Register address: 0 data, 1 status/command, 2 mode |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from the address while the read strobe is high |

## Verification
The assertions assume a well-formed host: each read or write strobe lasts one cycle, and the mode byte is written only while the receiver is idle. The bench writes the mode byte only between frames, after the previous frame's stop bit and idle time have passed. The bench also holds every line level for whole numbers of tick periods and starts each level just after a tick. The assertions on the engine's output assume reception stays on for a whole frame, and the bench changes the enable only while the line idles.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int CHAR_W = 8;

  // host register addresses
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;

  // command bit positions
  localparam int CMD_RX_ON  = 2;
  localparam int CMD_ERR_CL = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  // mask of valid data bits for a width code (00 -> 5 bits ... 11 -> 8 bits)
  function automatic logic [CHAR_W-1:0] width_mask(input logic [1:0] code);
    logic [CHAR_W-1:0] m;
    for (int i = 0; i < CHAR_W; i++) m[i] = (i < (int'(code) + 5));
    return m;
  endfunction

endpackage

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
  import serial_rx_pkg::*;
#(
  parameter int DIV_MID     = 16,
  parameter int DIV_HIGH    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx_line,
  input  logic              enable,
  input  logic [1:0]        fac_code,
  input  logic [1:0]        len_code,
  input  logic              par_en,
  input  logic              par_even,
  output logic              done_o,
  output logic [CHAR_W-1:0] char_o,
  output logic              perr_o,
  output logic              ferr_o
);

  localparam int CNT_W = $clog2(DIV_HIGH);
  localparam int IDX_W = $clog2(CHAR_W);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;

  rx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CHAR_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              done_d, perr_d, ferr_d;
  logic [CHAR_W-1:0] char_d;

  logic [CNT_W-1:0]  div_m1, half_m1;
  logic              one_x, bit_due;
  logic [IDX_W-1:0]  last_idx;

  // line synchronizer, idle level high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_line};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    one_x   = ~fac_code[1];
    div_m1  = fac_code[0] ? CNT_W'(DIV_HIGH - 1) : CNT_W'(DIV_MID - 1);
    half_m1 = fac_code[0] ? CNT_W'(DIV_HIGH / 2 - 1) : CNT_W'(DIV_MID / 2 - 1);
    if (one_x) div_m1 = '0;
    last_idx = IDX_W'(len_code) + IDX_W'(4);
    bit_due  = (cnt_q == div_m1);
  end

  // next state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    done_d = 1'b0;
    char_d = char_o;
    perr_d = perr_o;
    ferr_d = ferr_o;
    if (!enable) begin
      st_d = ST_IDLE;
    end else if (tick) begin
      unique case (st_q)
        ST_IDLE: if (!rx_s) begin
          cnt_d = '0;
          idx_d = '0;
          sh_d  = '0;
          st_d  = one_x ? ST_DATA : ST_START;
        end
        ST_START: begin
          if (cnt_q == half_m1) begin
            cnt_d = '0;
            st_d  = rx_s ? ST_IDLE : ST_DATA;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_DATA: begin
          if (bit_due) begin
            cnt_d       = '0;
            sh_d[idx_q] = rx_s;
            if (idx_q == last_idx) st_d = par_en ? ST_PAR : ST_STOP;
            else                   idx_d = idx_q + 1'b1;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_PAR: begin
          if (bit_due) begin
            cnt_d = '0;
            par_d = rx_s;
            st_d  = ST_STOP;
          end else cnt_d = cnt_q + 1'b1;
        end
        ST_STOP: begin
          if (bit_due) begin
            cnt_d  = '0;
            done_d = 1'b1;
            char_d = sh_q;
            ferr_d = ~rx_s;
            perr_d = par_en & (par_even ? (^sh_q ^ par_q) : ~(^sh_q ^ par_q));
            st_d   = ST_IDLE;
          end else cnt_d = cnt_q + 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      done_o <= 1'b0;
      char_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      done_o <= done_d;
      char_o <= char_d;
      perr_o <= perr_d;
      ferr_o <= ferr_d;
    end
  end

  // a finished character only ever leaves the stop-bit state
  p_done_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(st_q) == ST_STOP));

  // reception off forces the engine back to idle with no completion
  p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (st_q == ST_IDLE) && !done_o);

  // bits above the chosen width are zero on completion
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((char_o & ~width_mask(len_code)) == '0));

  // 1X never passes through start confirmation
  p_no_confirm_1x_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (one_x && st_q == ST_IDLE) |=> (st_q != ST_START));

endmodule

// File: rtl/rx_host_regs.sv
module rx_host_regs
  import serial_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [1:0]        addr,
  input  logic [7:0]        wdata,
  input  logic              done_i,
  input  logic [CHAR_W-1:0] char_i,
  input  logic              perr_i,
  input  logic              ferr_i,
  output logic [7:0]        rdata,
  output logic              rx_en,
  output logic [1:0]        fac_code,
  output logic [1:0]        len_code,
  output logic              par_en,
  output logic              par_even
);

  logic [5:0]        mode_q, mode_d;
  logic              en_q, en_d;
  logic [CHAR_W-1:0] buf_q, buf_d;
  logic              rdy_q, rdy_d;
  logic              pe_q, pe_d, oe_q, oe_d, fe_q, fe_d;
  logic              wr_mode, wr_cmd, rd_data, clr_err;
  logic [1:0]        unused_wbits;

  assign unused_wbits = wdata[7:6];

  always_comb begin
    wr_mode = wr && (addr == ADDR_MODE);
    wr_cmd  = wr && (addr == ADDR_CTRL);
    rd_data = rd && (addr == ADDR_DATA);
    clr_err = wr_cmd && wdata[CMD_ERR_CL];
  end

  // next state
  always_comb begin
    mode_d = wr_mode ? wdata[5:0] : mode_q;
    en_d   = wr_cmd ? wdata[CMD_RX_ON] : en_q;
    buf_d  = buf_q;
    rdy_d  = rdy_q & ~rd_data;
    pe_d   = pe_q & ~clr_err;
    oe_d   = oe_q & ~clr_err;
    fe_d   = fe_q & ~clr_err;
    if (done_i) begin
      buf_d = char_i;
      rdy_d = 1'b1;
      if (rdy_q && !rd_data) oe_d = 1'b1;
      if (perr_i) pe_d = 1'b1;
      if (ferr_i) fe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= 1'b0;
      buf_q  <= '0;
      rdy_q  <= 1'b0;
      pe_q   <= 1'b0;
      oe_q   <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      en_q   <= en_d;
      buf_q  <= buf_d;
      rdy_q  <= rdy_d;
      pe_q   <= pe_d;
      oe_q   <= oe_d;
      fe_q   <= fe_d;
    end
  end

  always_comb begin
    fac_code = mode_q[1:0];
    len_code = mode_q[3:2];
    par_en   = mode_q[4];
    par_even = mode_q[5];
    rx_en    = en_q;
    rdata    = '0;
    if (rd) begin
      unique case (addr)
        ADDR_DATA: rdata = buf_q;
        ADDR_CTRL: rdata = {2'b00, fe_q, oe_q, pe_q, 1'b0, rdy_q, 1'b0};
        default:   rdata = '0;
      endcase
    end
  end

  p_ready_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> rdy_q);

  p_ready_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !done_i) |=> !rdy_q);

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && rdy_q && !rd_data) |=> oe_q);

  p_framing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && ferr_i) |=> (fe_q && rdy_q));

  p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_err && !done_i) |=> !(pe_q || oe_q || fe_q));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_err && !done_i) |=> $stable({pe_q, oe_q, fe_q}));

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
  import serial_rx_pkg::*;
#(
  parameter int DIV_MID     = 16,
  parameter int DIV_HIGH    = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       os_tick,
  input  logic       rx_line,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [1:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              rx_en, par_en, par_even;
  logic [1:0]        fac_code, len_code;
  logic              done, perr, ferr;
  logic [CHAR_W-1:0] char_v;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  rx_host_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr       (host_wr),
    .rd       (host_rd),
    .addr     (host_addr),
    .wdata    (host_wdata),
    .done_i   (done),
    .char_i   (char_v),
    .perr_i   (perr),
    .ferr_i   (ferr),
    .rdata    (host_rdata),
    .rx_en    (rx_en),
    .fac_code (fac_code),
    .len_code (len_code),
    .par_en   (par_en),
    .par_even (par_even)
  );

  rx_bit_engine #(
    .DIV_MID     (DIV_MID),
    .DIV_HIGH    (DIV_HIGH),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .tick     (os_tick),
    .rx_line  (rx_line),
    .enable   (rx_en),
    .fac_code (fac_code),
    .len_code (len_code),
    .par_en   (par_en),
    .par_even (par_even),
    .done_o   (done),
    .char_o   (char_v),
    .perr_o   (perr),
    .ferr_o   (ferr)
  );

endmodule

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;

  localparam int TICK_CYC = 4;
  localparam int NVEC     = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick;
  logic       rx_line = 1'b1;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'd0;
  logic [7:0] host_rdata;
  logic [1:0] tcnt = 2'd0;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) tcnt <= tcnt + 2'd1;
  assign os_tick = (tcnt == 2'd3);

  serial_rx_core u_serial_rx_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .os_tick    (os_tick),
    .rx_line    (rx_line),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
  );

  // vector: {mode, data, flags(bit0 bad parity, bit1 low stop), exp status, exp data}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'h0D, 8'hA5, 8'h00, 8'h02, 8'hA5},  // R2 R4 8 bits 1X
    {8'h02, 8'hFF, 8'h00, 8'h02, 8'h1F},  // R2 5 bits 16X
    {8'h3A, 8'h53, 8'h00, 8'h02, 8'h53},  // R3 7 bits even 16X
    {8'h3A, 8'h53, 8'h01, 8'h0A, 8'h53},  // R3 even mismatch
    {8'h17, 8'h2C, 8'h00, 8'h02, 8'h2C},  // R3 R4 6 bits odd 64X
    {8'h0E, 8'h3C, 8'h02, 8'h22, 8'h3C},  // R9 low stop 16X
    {8'h05, 8'hC7, 8'h00, 8'h02, 8'h07},  // R2 6 bits 1X
    {8'h1D, 8'h81, 8'h01, 8'h0A, 8'h81}   // R3 odd mismatch 1X
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic hold(input logic v, input int ticks);
    rx_line = v;
    repeat (ticks * TICK_CYC) @(negedge clk);
  endtask

  // align line changes to just after a tick edge
  task automatic align;
    @(posedge clk iff tcnt == 2'd3);
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] mode, input logic [7:0] d,
                      input logic bad_par, input logic low_stop);
    int div, len;
    logic p;
    div = (mode[1:0] == 2'b11) ? 64 : (mode[1:0] == 2'b10) ? 16 : 1;
    len = int'(mode[3:2]) + 5;
    p = 1'b0;
    for (int i = 0; i < len; i++) p ^= d[i];
    if (!mode[5]) p = ~p;
    p ^= bad_par;
    align();
    hold(1'b0, div);
    for (int i = 0; i < len; i++) hold(d[i], div);
    if (mode[4]) hold(p, div);
    hold(~low_stop, div);
    hold(1'b1, 2 * div + 4);
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    host_read(2'd1, r); check("R1 status", r, 8'h00);
    host_read(2'd0, r); check("R1 data", r, 8'h00);

    // R6 reception off: frame ignored
    host_write(2'd2, 8'h0D);
    send(8'h0D, 8'h5A, 1'b0, 1'b0);
    host_write(2'd1, 8'h04);
    host_read(2'd1, r); check("R6 status while off", r, 8'h00);
    host_read(2'd0, r); check("R6 data while off", r, 8'h00);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      logic [39:0] v;
      v = VEC[i];
      host_write(2'd2, v[39:32]);
      host_write(2'd1, 8'h14);
      send(v[39:32], v[31:24], v[16], v[17]);
      host_read(2'd1, r); check("R2/R3/R4/R9 status", r, v[15:8]);
      host_read(2'd0, r); check("R2/R3/R4/R9 data", r, v[7:0]);
      host_read(2'd1, r); check("R7 ready cleared", r, v[15:8] & 8'hFD);
    end

    // R5 glitch at 16X
    host_write(2'd2, 8'h0E);
    host_write(2'd1, 8'h14);
    align();
    hold(1'b0, 3);
    hold(1'b1, 40);
    host_read(2'd1, r); check("R5 glitch ignored", r, 8'h00);
    send(8'h0E, 8'h96, 1'b0, 1'b0);
    host_read(2'd1, r); check("R5 frame after glitch", r, 8'h02);
    host_read(2'd0, r); check("R5 data after glitch", r, 8'h96);

    // R8 overrun
    host_write(2'd2, 8'h0D);
    send(8'h0D, 8'h11, 1'b0, 1'b0);
    send(8'h0D, 8'h22, 1'b0, 1'b0);
    host_read(2'd1, r); check("R8 overrun status", r, 8'h12);
    host_read(2'd0, r); check("R8 newest kept", r, 8'h22);

    // R10 stickiness and clear
    host_read(2'd1, r); check("R10 sticky after read", r, 8'h10);
    host_write(2'd1, 8'h04);
    host_read(2'd1, r); check("R10 sticky after cmd", r, 8'h10);
    send(8'h0D, 8'h33, 1'b0, 1'b0);
    host_read(2'd1, r); check("R10 sticky after clean frame", r, 8'h12);
    host_write(2'd1, 8'h14);
    host_read(2'd1, r); check("R10 cleared", r, 8'h02);
    host_read(2'd0, r); check("R7 data", r, 8'h33);
    host_read(2'd3, r); check("R10 unmapped read", r, 8'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule